// File: doc/BRIEF.md
# BLDC Hall Commutation Gate Controller

This block is the digital core of a three-phase brushless motor driver. It reads three Hall sensor levels and a direction bit, and turns them into six gate enables: one high-side and one low-side switch per phase. In each valid rotor position, one phase sources current, a different phase sinks it, and the third phase floats.

A PWM input chops the selected pair, with a decay style chosen live. A hold input and a brake input override commutation in a fixed order: hold first, then brake, then PWM. A brake-select input decides whether hold and undervoltage coast the motor or brake it.

Fault inputs for undervoltage, overtemperature and a phase shorted to ground are plain logic levels. They are merged with the block's own invalid-Hall detection into one active-low fault flag. A short to ground is remembered until the rotor commutates or hold is asserted.

Top module: `bldc_commutator`

## Requirements
- R1: While `hold`=1, all gates are off if `brake_sel`=0. If `brake_sel`=1, all three low-sides are on and all high-sides are off.
- R2: `hold`=1 wins over `brake`. With `hold`=0, `brake`=1 drives `gate_lo`=3'b111 and `gate_hi`=3'b000, whatever `pwm` is.
- R3: With `dir_rev`=0 and no override or fault, the Hall value {hall[2],hall[1],hall[0]} selects the gates as follows. Phase A is bit 0, B is bit 1 and C is bit 2 of `gate_hi` and `gate_lo`.
  - 5: high A, low B
  - 4: high A, low C
  - 6: high B, low C
  - 2: high B, low A
  - 3: high C, low A
  - 1: high C, low B
  - `fault_n` stays 1.
- R4: With `dir_rev`=1, each valid Hall value drives the R3 pattern with the high-side and low-side vectors exchanged.
- R5: With `pwm`=0 and `slow_decay`=1, the selected high-side is off and the selected low-side stays on.
- R6: With `pwm`=0 and `slow_decay`=0, both selected switches are off.
- R7: A synchronized Hall value of 0 or 7 turns every gate off and drives `fault_n` to 0.
- R8: `therm_fault`=1 turns every gate off and drives `fault_n` to 0.
- R9: `uv_fault`=1 drives `fault_n` to 0 and applies the R1 coast-or-brake choice set by `brake_sel`.
- R10: `gnd_fault`=1 forces every high-side off in the same cycle and drives `fault_n` to 0. It also sets a latch from the next clock edge. The latch keeps high-sides off and `fault_n` at 0 until the synchronized Hall value changes or `hold` is 1 at a clock edge.
- R11: Hall inputs pass through `SYNC_STAGES` (default 2) flops. A change at the pins reaches the gates after exactly that many rising edges.
- R12: After `rst_n` is released with Hall pins at 0, all gates are off and `fault_n` is 0.
- R13: No phase ever has its high-side and low-side gate on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall | input | 3 | Raw Hall sensor levels |
| dir_rev | input | 1 | 1 reverses rotation |
| pwm | input | 1 | Chopping input, 1 = drive |
| slow_decay | input | 1 | 1 = slow decay, 0 = fast decay on PWM off |
| hold | input | 1 | Disable commutation (coast or brake) |
| brake | input | 1 | Brake request |
| brake_sel | input | 1 | 1 = brake, 0 = coast under hold or undervoltage |
| uv_fault | input | 1 | Undervoltage detected |
| therm_fault | input | 1 | Overtemperature detected |
| gnd_fault | input | 1 | Phase short to ground detected |
| gate_hi | output | 3 | High-side gate enables, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gate enables, bit 0 = phase A |
| fault_n | output | 1 | Active-low fault flag |

## Verification
The assertions assume that every override and fault input is already synchronous to `clk`. Only the Hall pins are treated as asynchronous. The short-latch property also assumes that a short pulse is seen at a clock edge.

The bench drives every input at the falling edge and samples one time step later. A Hall change is always held for at least the synchronizer depth plus one edge. This makes every decoded state and every latch clear event visible before the next stimulus.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
   localparam int NPH = 3;
   typedef logic [NPH-1:0] ph_vec_t;

   typedef struct packed {
      ph_vec_t hi;
      ph_vec_t lo;
   } gate_pair_t;

   // Forward-direction pattern for a Hall code; zero for invalid codes.
   function automatic gate_pair_t fwd_pattern(input logic [2:0] code);
      gate_pair_t g;
      g = '0;
      case (code)
         3'd5: begin g.hi = 3'b001; g.lo = 3'b010; end
         3'd4: begin g.hi = 3'b001; g.lo = 3'b100; end
         3'd6: begin g.hi = 3'b010; g.lo = 3'b100; end
         3'd2: begin g.hi = 3'b010; g.lo = 3'b001; end
         3'd3: begin g.hi = 3'b100; g.lo = 3'b001; end
         3'd1: begin g.hi = 3'b100; g.lo = 3'b010; end
         default: g = '0;
      endcase
      return g;
   endfunction
endpackage

// File: rtl/bldc_hall_sync.sv
module bldc_hall_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] synced,
   output logic             changed,
   output logic             code_ok
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("bldc_hall_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe;
   logic [WIDTH-1:0]             prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
         prev <= '0;
      end else begin
         pipe[0] <= raw;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
         prev <= pipe[LAST];
      end
   end

   assign synced  = pipe[LAST];
   assign changed = (pipe[LAST] != prev);
   assign code_ok = (pipe[LAST] != '0) && (pipe[LAST] != '1);
endmodule

// File: rtl/bldc_comm_decode.sv
module bldc_comm_decode
   import bldc_pkg::*;
(
   input  logic [2:0] code,
   input  logic       dir_rev,
   output ph_vec_t    comm_hi,
   output ph_vec_t    comm_lo
);
   gate_pair_t base;

   always_comb begin
      base = fwd_pattern(code);
      if (dir_rev) begin
         comm_hi = base.lo;
         comm_lo = base.hi;
      end else begin
         comm_hi = base.hi;
         comm_lo = base.lo;
      end
   end
endmodule

// File: rtl/bldc_short_latch.sv
module bldc_short_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic short_in,
   input  logic commutated,
   input  logic hold,
   output logic latched
);
   logic clr;
   assign clr = commutated | hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latched <= 1'b0;
      else        latched <= short_in | (latched & ~clr);
   end
endmodule

// File: rtl/bldc_gate_arbiter.sv
module bldc_gate_arbiter
   import bldc_pkg::*;
(
   input  ph_vec_t comm_hi,
   input  ph_vec_t comm_lo,
   input  logic    pwm,
   input  logic    slow_decay,
   input  logic    hold,
   input  logic    brake,
   input  logic    brake_sel,
   input  logic    code_ok,
   input  logic    uv_fault,
   input  logic    therm_fault,
   input  logic    hi_mask,
   output ph_vec_t gate_hi,
   output ph_vec_t gate_lo
);
   logic    coast, stop, all_lo;
   ph_vec_t pre_hi, pre_lo;

   assign coast  = ~code_ok | therm_fault;
   assign stop   = hold | uv_fault;
   assign all_lo = (stop & brake_sel) | (~stop & brake);

   always_comb begin
      if (coast) begin
         pre_hi = '0;
         pre_lo = '0;
      end else if (stop || brake) begin
         pre_hi = '0;
         pre_lo = {NPH{all_lo}};
      end else begin
         pre_hi = comm_hi & {NPH{pwm}};
         pre_lo = comm_lo & {NPH{pwm | slow_decay}};
      end
   end

   generate
      for (genvar p = 0; p < NPH; p++) begin : g_phase
         assign gate_hi[p] = pre_hi[p] & ~hi_mask & ~pre_lo[p];
         assign gate_lo[p] = pre_lo[p];
      end
   endgenerate
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall,
   input  logic       dir_rev,
   input  logic       pwm,
   input  logic       slow_decay,
   input  logic       hold,
   input  logic       brake,
   input  logic       brake_sel,
   input  logic       uv_fault,
   input  logic       therm_fault,
   input  logic       gnd_fault,
   output logic [2:0] gate_hi,
   output logic [2:0] gate_lo,
   output logic       fault_n
);
   logic [2:0] hall_s;
   logic       hall_chg, hall_ok, gnd_latched;
   ph_vec_t    comm_hi, comm_lo;

   bldc_hall_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(hall),
      .synced(hall_s), .changed(hall_chg), .code_ok(hall_ok)
   );

   bldc_comm_decode u_dec (
      .code(hall_s), .dir_rev(dir_rev),
      .comm_hi(comm_hi), .comm_lo(comm_lo)
   );

   bldc_short_latch u_latch (
      .clk(clk), .rst_n(rst_n), .short_in(gnd_fault),
      .commutated(hall_chg), .hold(hold), .latched(gnd_latched)
   );

   bldc_gate_arbiter u_arb (
      .comm_hi(comm_hi), .comm_lo(comm_lo), .pwm(pwm),
      .slow_decay(slow_decay), .hold(hold), .brake(brake),
      .brake_sel(brake_sel), .code_ok(hall_ok), .uv_fault(uv_fault),
      .therm_fault(therm_fault), .hi_mask(gnd_fault | gnd_latched),
      .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   assign fault_n = ~(~hall_ok | uv_fault | therm_fault | gnd_fault | gnd_latched);
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hold,
   input logic       brake,
   input logic       brake_sel,
   input logic       pwm,
   input logic       uv_fault,
   input logic       therm_fault,
   input logic       gnd_fault,
   input logic       hall_ok,
   input logic       latched,
   input logic [2:0] gate_hi,
   input logic [2:0] gate_lo,
   input logic       fault_n
);
   AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi & gate_lo) == 3'b000); // R13
   AST_HOLD_COAST: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !brake_sel) |-> (gate_hi == 3'b000 && gate_lo == 3'b000)); // R1
   AST_BRAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (brake && !hold && !uv_fault && !therm_fault && hall_ok)
      |-> (gate_hi == 3'b000 && gate_lo == 3'b111)); // R2
   AST_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !brake && !uv_fault && !therm_fault && !gnd_fault && !latched && hall_ok && pwm)
      |-> ($countones(gate_hi) == 1 && $countones(gate_lo) == 1 && fault_n)); // R3
   AST_THERM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      therm_fault |-> (gate_hi == 3'b000 && gate_lo == 3'b000 && !fault_n)); // R8
   AST_GND_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      gnd_fault |-> (gate_hi == 3'b000 && !fault_n)); // R10
   AST_GND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      gnd_fault |=> (!fault_n && gate_hi == 3'b000)); // R10
   AST_BAD_HALL: assert property (@(posedge clk) disable iff (!rst_n)
      !hall_ok |-> (gate_hi == 3'b000 && gate_lo == 3'b000 && !fault_n)); // R7
endmodule

bind bldc_commutator bldc_commutator_chk chk_i (
   .clk(clk), .rst_n(rst_n), .hold(hold), .brake(brake),
   .brake_sel(brake_sel), .pwm(pwm), .uv_fault(uv_fault),
   .therm_fault(therm_fault), .gnd_fault(gnd_fault), .hall_ok(hall_ok),
   .latched(gnd_latched), .gate_hi(gate_hi), .gate_lo(gate_lo),
   .fault_n(fault_n)
);

// File: tb/bldc_commutator_tb_top.sv
module bldc_commutator_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall = 3'd0;
   logic       dir_rev = 1'b0, pwm = 1'b1, slow_decay = 1'b1, hold = 1'b0;
   logic       brake = 1'b0, brake_sel = 1'b0, uv_fault = 1'b0;
   logic       therm_fault = 1'b0, gnd_fault = 1'b0;
   logic [2:0] gate_hi, gate_lo;
   logic       fault_n;
   int         errors = 0, checks = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bldc_commutator dut_i (
      .clk(clk), .rst_n(rst_n), .hall(hall), .dir_rev(dir_rev), .pwm(pwm),
      .slow_decay(slow_decay), .hold(hold), .brake(brake), .brake_sel(brake_sel),
      .uv_fault(uv_fault), .therm_fault(therm_fault), .gnd_fault(gnd_fault),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
   );

   task automatic chk(input string tag, input logic [6:0] exp);
      logic [6:0] got;
      got = {gate_hi, gate_lo, fault_n};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got hi=%b lo=%b fn=%b expected hi=%b lo=%b fn=%b",
                  tag, got[6:4], got[3:1], got[0], exp[6:4], exp[3:1], exp[0]);
      end
   endtask

   function automatic logic [5:0] ref_pair(input logic [2:0] c, input logic rev);
      logic [5:0] p;
      case (c)
         3'd5: p = {3'b001, 3'b010};
         3'd4: p = {3'b001, 3'b100};
         3'd6: p = {3'b010, 3'b100};
         3'd2: p = {3'b010, 3'b001};
         3'd3: p = {3'b100, 3'b001};
         3'd1: p = {3'b100, 3'b010};
         default: p = '0;
      endcase
      return rev ? {p[2:0], p[5:3]} : p;
   endfunction

   task automatic set_hall(input logic [2:0] v);
      @(negedge clk) hall = v;
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset;
      chk("R12 reset state", {3'b000, 3'b000, 1'b0});
   endtask

   task automatic t_forward;
      logic [2:0] seq [6] = '{3'd5, 3'd4, 3'd6, 3'd2, 3'd3, 3'd1};
      dir_rev = 1'b0;
      foreach (seq[i]) begin
         set_hall(seq[i]);
         chk("R3 forward", {ref_pair(seq[i], 1'b0), 1'b1});
      end
   endtask

   task automatic t_reverse;
      @(negedge clk) dir_rev = 1'b1;
      #1 chk("R4 reverse state 1", {ref_pair(3'd1, 1'b1), 1'b1});
      set_hall(3'd3);
      chk("R4 reverse state 3", {ref_pair(3'd3, 1'b1), 1'b1});
      set_hall(3'd6);
      chk("R4 reverse state 6", {ref_pair(3'd6, 1'b1), 1'b1});
      @(negedge clk) dir_rev = 1'b0;
   endtask

   task automatic t_decay;
      set_hall(3'd5);
      @(negedge clk) begin pwm = 1'b0; slow_decay = 1'b1; end
      #1 chk("R5 slow decay", {3'b000, 3'b010, 1'b1});
      @(negedge clk) slow_decay = 1'b0;
      #1 chk("R6 fast decay", {3'b000, 3'b000, 1'b1});
      @(negedge clk) pwm = 1'b1;
      #1 chk("R6 pwm back on", {3'b001, 3'b010, 1'b1});
   endtask

   task automatic t_override;
      @(negedge clk) begin hold = 1'b1; brake_sel = 1'b0; brake = 1'b1; end
      #1 chk("R1 R2 hold coast beats brake", {3'b000, 3'b000, 1'b1});
      @(negedge clk) brake_sel = 1'b1;
      #1 chk("R1 hold brake", {3'b000, 3'b111, 1'b1});
      @(negedge clk) begin hold = 1'b0; pwm = 1'b0; end
      #1 chk("R2 brake beats pwm", {3'b000, 3'b111, 1'b1});
      @(negedge clk) begin brake = 1'b0; pwm = 1'b1; brake_sel = 1'b0; end
      #1 chk("R2 release", {3'b001, 3'b010, 1'b1});
   endtask

   task automatic t_invalid;
      set_hall(3'd7);
      chk("R7 code 7", {3'b000, 3'b000, 1'b0});
      set_hall(3'd0);
      chk("R7 code 0", {3'b000, 3'b000, 1'b0});
      set_hall(3'd2);
      chk("R7 recover", {3'b010, 3'b001, 1'b1});
   endtask

   task automatic t_faults;
      @(negedge clk) begin therm_fault = 1'b1; brake_sel = 1'b1; end
      #1 chk("R8 thermal coast", {3'b000, 3'b000, 1'b0});
      @(negedge clk) begin therm_fault = 1'b0; uv_fault = 1'b1; end
      #1 chk("R9 uv brake", {3'b000, 3'b111, 1'b0});
      @(negedge clk) brake_sel = 1'b0;
      #1 chk("R9 uv coast", {3'b000, 3'b000, 1'b0});
      @(negedge clk) uv_fault = 1'b0;
      #1 chk("R9 recover", {3'b010, 3'b001, 1'b1});
   endtask

   task automatic t_short;
      set_hall(3'd5);
      @(negedge clk) gnd_fault = 1'b1;
      #1 chk("R10 immediate", {3'b000, 3'b010, 1'b0});
      @(negedge clk) gnd_fault = 1'b0;
      #1 chk("R10 latched", {3'b000, 3'b010, 1'b0});
      repeat (3) @(negedge clk);
      #1 chk("R10 still latched", {3'b000, 3'b010, 1'b0});
      @(negedge clk) hold = 1'b1;
      @(negedge clk) hold = 1'b0;
      #1 chk("R10 hold clears", {3'b001, 3'b010, 1'b1});
      @(negedge clk) gnd_fault = 1'b1;
      @(negedge clk) gnd_fault = 1'b0;
      set_hall(3'd4);
      @(negedge clk);
      #1 chk("R10 commutation clears", {3'b001, 3'b100, 1'b1});
   endtask

   task automatic t_sync;
      @(negedge clk) hall = 3'd6;
      @(negedge clk);
      #1 chk("R11 one edge old", {ref_pair(3'd4, 1'b0), 1'b1});
      @(negedge clk);
      #1 chk("R11 two edges new", {ref_pair(3'd6, 1'b0), 1'b1});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_forward();
      t_reverse();
      t_decay();
      t_override();
      t_invalid();
      t_faults();
      t_short();
      t_sync();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule